// File: doc/BRIEF.md
# Ethernet Pause Flow-Control Controller

This block manages link-level pause behaviour for one Ethernet port. In one direction it watches the receive buffer fill level. It asks the transmit path for a pause frame (XOFF) when the buffer gets too full. When the buffer drains again it can ask for a resume frame (XON). In the other direction it takes a decoded "pause frame received" strobe from the receive parser and holds the local transmitter for the requested time.

A two-bit mode turns each direction on or off on its own. Hysteresis between a high and a low fill mark stops the block from sending pause frames again and again. Each request carries a quanta value and waits on a valid/ready handshake until the frame builder accepts it. The hold timer counts quanta of 512 bit times. The datapath moves one 64-bit word per clock, so each quanta lasts 8 clocks at the default parameters.

Top module: `pause_flow_ctrl`

## Requirements
- R1: `cfg_mode` is decoded as follows: 2'b00 does nothing, 2'b01 honours received pause only, 2'b10 generates pause only, and 2'b11 does both. Bit 1 enables generation and bit 0 enables honouring.
- R2: With generation enabled and not paused, an edge that samples `rx_occ >= cfg_hi_mark` raises `tx_req_valid` after that edge, with `tx_req_quanta` equal to `cfg_pause_time` (XOFF).
- R3: Once paused, no further request is made while the occupancy stays at or above the low mark, even when it is above the high mark.
- R4: While paused and with `cfg_xon_en` = 1, an occupancy strictly below `cfg_lo_mark` clears the paused state and requests an XON, which has `tx_req_quanta` = 0. An occupancy equal to the low mark does not.
- R5: With `cfg_xon_en` = 0, falling below the low mark clears the paused state with no request, so a later rise to the high mark gives a new XOFF.
- R6: With generation disabled, no request is made, any pending request is withdrawn on the next edge, and the paused state is cleared.
- R7: A pending request keeps `tx_req_valid` high and `tx_req_quanta` stable until it is accepted (`tx_req_ready` high at an edge). `tx_req_valid` then falls after that edge.
- R8: With honouring enabled, a `rx_pause_stb` with quanta Q != 0 holds `tx_hold` high for exactly Q*512/WORD_BITS clocks, starting the cycle after the strobe.
- R9: A received strobe with quanta 0 drops `tx_hold` on the next edge.
- R10: With honouring disabled, strobes are ignored and an active hold ends on the next edge.
- R11: Reset (`rst_n` low) clears `tx_req_valid`, `tx_req_quanta`, `tx_hold` and the paused state.
- R12: A strobe that arrives during an active hold restarts the countdown from its own quanta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Bit 1 = generate pause, bit 0 = honour pause |
| cfg_pause_time | input | QUANTA_W | Quanta placed in XOFF requests |
| cfg_hi_mark | input | OCC_W | Occupancy at or above which XOFF is requested |
| cfg_lo_mark | input | OCC_W | Occupancy below which the paused state ends |
| cfg_xon_en | input | 1 | Send an XON when the paused state ends |
| rx_occ | input | OCC_W | Receive buffer occupancy |
| rx_pause_stb | input | 1 | One-cycle strobe: pause frame received |
| rx_pause_quanta | input | QUANTA_W | Quanta carried by the received pause frame |
| tx_req_valid | output | 1 | Pause frame request pending |
| tx_req_ready | input | 1 | Frame builder accepts the request |
| tx_req_quanta | output | QUANTA_W | Quanta for the requested frame (0 = XON) |
| tx_hold | output | 1 | Hold local transmission |

## Verification
The bench drives the occupancy exactly onto both marks. A design that compares the wrong way round would pause one word late, or send XON at the low mark itself. It keeps the occupancy above the high mark through an accepted XOFF. A design without hysteresis would send XOFF again at once. It switches the mode off while a request is pending. A design that keeps the paused state would never send the next XOFF. It also counts the hold length clock by clock, cancels a hold with a zero-quanta strobe, and reloads the hold while it is running. Each of these would show up as an off-by-one length, a hold that does not end, or a leftover hold.

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
  parameter int OCC_W     = 12,
  parameter int QUANTA_W  = 16,
  parameter int WORD_BITS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_mode,
  input  logic [QUANTA_W-1:0] cfg_pause_time,
  input  logic [OCC_W-1:0]    cfg_hi_mark,
  input  logic [OCC_W-1:0]    cfg_lo_mark,
  input  logic                cfg_xon_en,
  input  logic [OCC_W-1:0]    rx_occ,
  input  logic                rx_pause_stb,
  input  logic [QUANTA_W-1:0] rx_pause_quanta,
  output logic                tx_req_valid,
  input  logic                tx_req_ready,
  output logic [QUANTA_W-1:0] tx_req_quanta,
  output logic                tx_hold
);
  localparam int SHIFT = $clog2(512 / WORD_BITS);
  localparam int CNT_W = QUANTA_W + SHIFT;

  logic             gen_en, hon_en, paused;
  logic [OCC_W-1:0] hi_eff, lo_eff;
  logic [CNT_W-1:0] hold_cnt;

  assign gen_en  = cfg_mode[1];
  assign hon_en  = cfg_mode[0];
  assign hi_eff  = gen_en ? cfg_hi_mark : '0;
  assign lo_eff  = gen_en ? cfg_lo_mark : '0;
  assign tx_hold = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      paused        <= 1'b0;
      tx_req_valid  <= 1'b0;
      tx_req_quanta <= '0;
    end else if (!gen_en) begin
      paused       <= 1'b0;
      tx_req_valid <= 1'b0;
    end else if (tx_req_valid) begin
      if (tx_req_ready) tx_req_valid <= 1'b0;
    end else if (!paused && rx_occ >= hi_eff) begin
      paused        <= 1'b1;
      tx_req_valid  <= 1'b1;
      tx_req_quanta <= cfg_pause_time;
    end else if (paused && rx_occ < lo_eff) begin
      paused <= 1'b0;
      if (cfg_xon_en) begin
        tx_req_valid  <= 1'b1;
        tx_req_quanta <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !hon_en)
      hold_cnt <= '0;
    else if (rx_pause_stb)
      hold_cnt <= CNT_W'(rx_pause_quanta) << SHIFT;
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;
  end
endmodule

module pause_flow_ctrl_chk #(
  parameter int OCC_W    = 12,
  parameter int QUANTA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          cfg_mode,
  input logic [QUANTA_W-1:0] cfg_pause_time,
  input logic [OCC_W-1:0]    cfg_hi_mark,
  input logic [OCC_W-1:0]    rx_occ,
  input logic                rx_pause_stb,
  input logic [QUANTA_W-1:0] rx_pause_quanta,
  input logic                tx_req_valid,
  input logic                tx_req_ready,
  input logic [QUANTA_W-1:0] tx_req_quanta,
  input logic                tx_hold
);
  // R2
  xoff_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_req_valid) && tx_req_quanta != '0) |->
      ($past(rx_occ) >= $past(cfg_hi_mark) && tx_req_quanta == $past(cfg_pause_time)));
  // R6
  gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode[1] |=> !tx_req_valid);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_valid && !tx_req_ready && cfg_mode[1]) |=> (tx_req_valid && $stable(tx_req_quanta)));
  // R8
  hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_stb && cfg_mode[0] && rx_pause_quanta != '0) |=> tx_hold);
  // R9
  zero_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_stb && cfg_mode[0] && rx_pause_quanta == '0) |=> !tx_hold);
  // R10
  honour_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode[0] |=> !tx_hold);
endmodule

bind pause_flow_ctrl pause_flow_ctrl_chk #(.OCC_W(OCC_W), .QUANTA_W(QUANTA_W)) u_chk (.*);

// File: tb/pause_flow_ctrl_bench.sv
module pause_flow_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd3;
  logic [15:0] cfg_pause_time = 16'h0123;
  logic [11:0] cfg_hi_mark = 12'd100;
  logic [11:0] cfg_lo_mark = 12'd40;
  logic        cfg_xon_en = 1'b1;
  logic [11:0] rx_occ = '0;
  logic        rx_pause_stb = 1'b0;
  logic [15:0] rx_pause_quanta = '0;
  logic        tx_req_valid, tx_req_ready = 1'b0;
  logic [15:0] tx_req_quanta;
  logic        tx_hold;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5ns clk = ~clk;

  pause_flow_ctrl u_pause_flow_ctrl (.*);

  // req[36:33] mode[32:31] xon[30] occ[29:18] rdy[17] exp_valid[16] exp_quanta[15:0]
  localparam logic [36:0] VEC [0:19] = '{
    {4'd11, 2'd3, 1'b1, 12'd10,  1'b0, 1'b0, 16'h0000},
    {4'd2,  2'd3, 1'b1, 12'd100, 1'b0, 1'b1, 16'h0123}, // R2 at high mark
    {4'd7,  2'd3, 1'b1, 12'd120, 1'b0, 1'b1, 16'h0123}, // R7 held
    {4'd7,  2'd3, 1'b1, 12'd120, 1'b1, 1'b0, 16'h0123}, // R7 accepted
    {4'd3,  2'd3, 1'b1, 12'd120, 1'b0, 1'b0, 16'h0123}, // R3 no repeat
    {4'd4,  2'd3, 1'b1, 12'd40,  1'b0, 1'b0, 16'h0123}, // R4 equal to low
    {4'd4,  2'd3, 1'b1, 12'd39,  1'b0, 1'b1, 16'h0000}, // R4 XON
    {4'd7,  2'd3, 1'b1, 12'd39,  1'b1, 1'b0, 16'h0000},
    {4'd2,  2'd3, 1'b1, 12'd99,  1'b0, 1'b0, 16'h0000}, // R2 below high
    {4'd2,  2'd3, 1'b0, 12'd100, 1'b0, 1'b1, 16'h0123},
    {4'd7,  2'd3, 1'b0, 12'd100, 1'b1, 1'b0, 16'h0123},
    {4'd5,  2'd3, 1'b0, 12'd10,  1'b0, 1'b0, 16'h0123}, // R5 silent clear
    {4'd5,  2'd3, 1'b0, 12'd100, 1'b0, 1'b1, 16'h0123}, // R5 re-armed
    {4'd7,  2'd3, 1'b0, 12'd100, 1'b1, 1'b0, 16'h0123},
    {4'd6,  2'd1, 1'b1, 12'd10,  1'b0, 1'b0, 16'h0123}, // R6 clears paused
    {4'd6,  2'd1, 1'b1, 12'd200, 1'b0, 1'b0, 16'h0123}, // R6 no request
    {4'd6,  2'd3, 1'b1, 12'd200, 1'b0, 1'b1, 16'h0123}, // R6 paused was cleared
    {4'd6,  2'd0, 1'b1, 12'd200, 1'b0, 1'b0, 16'h0123}, // R6 withdrawn
    {4'd1,  2'd2, 1'b1, 12'd200, 1'b0, 1'b1, 16'h0123}, // R1 generate-only
    {4'd7,  2'd2, 1'b1, 12'd200, 1'b1, 1'b0, 16'h0123}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [15:0] q);
    rx_pause_quanta = q;
    rx_pause_stb = 1'b1;
    @(negedge clk);
    rx_pause_stb = 1'b0;
  endtask

  function automatic int hold_len();
    return 0;
  endfunction

  task automatic count_hold(output int n);
    n = 0;
    while (tx_hold && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(!tx_req_valid && !tx_hold && tx_req_quanta == 0, "R11 reset state",
          {tx_req_valid, tx_hold}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cfg_mode     = VEC[i][32:31];
      cfg_xon_en   = VEC[i][30];
      rx_occ       = VEC[i][29:18];
      tx_req_ready = VEC[i][17];
      @(negedge clk);
      check(tx_req_valid == VEC[i][16], $sformatf("R%0d row %0d valid", VEC[i][36:33], i),
            tx_req_valid, VEC[i][16]);
      check(tx_req_quanta == VEC[i][15:0], $sformatf("R%0d row %0d quanta", VEC[i][36:33], i),
            tx_req_quanta, VEC[i][15:0]);
    end
    tx_req_ready = 1'b1;
    cfg_xon_en = 1'b0;
    rx_occ = '0;
    cfg_mode = 2'd3;
    repeat (2) @(negedge clk);

    pulse(16'd2);
    count_hold(n);
    check(n == 16, "R8 hold length", n, 16);

    pulse(16'd3);
    repeat (4) @(negedge clk);
    pulse(16'd1);
    count_hold(n);
    check(n == 8, "R12 reload length", n, 8);

    pulse(16'd10);
    check(tx_hold, "R9 hold before cancel", tx_hold, 1);
    pulse(16'd0);
    check(!tx_hold, "R9 zero quanta cancel", tx_hold, 0);

    cfg_mode = 2'd2;
    pulse(16'd5);
    check(!tx_hold, "R10 strobe ignored", tx_hold, 0);
    cfg_mode = 2'd3;
    pulse(16'd5);
    cfg_mode = 2'd2;
    @(negedge clk);
    check(!tx_hold, "R10 active hold ended", tx_hold, 0);
    check(!tx_req_valid, "R10 no request at zero occupancy", tx_req_valid, 0);

    cfg_mode = 2'd1;
    pulse(16'd1);
    check(tx_hold, "R1 receive-only honours", tx_hold, 1);
    repeat (10) @(negedge clk);

    cfg_mode = 2'd3;
    tx_req_ready = 1'b0;
    rx_occ = 12'd200;
    @(negedge clk);
    check(tx_req_valid, "R11 request before reset", tx_req_valid, 1);
    pulse(16'd4);
    rst_n = 1'b0;
    @(negedge clk);
    check(!tx_req_valid && !tx_hold && tx_req_quanta == 0, "R11 mid-run reset",
          {tx_req_valid, tx_hold}, 0);
    rst_n = 1'b1;
    rx_occ = '0;
    @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule